// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a 32-word by 16-bit circular buffer that sits between a host register port and a card-side data stream. The direction input selects which side fills the buffer. When it reads card-to-host, the card pushes and the host pops. When it reads host-to-card, the host pushes and the card pops.

Two programmable levels watch the occupancy, one for each direction. For received data, the fill level is compared against an almost-full threshold. For transmitted data, it is compared against an almost-empty threshold. A per-direction enable in the configuration word decides how a crossing is reported: either a DMA request line for a DMA engine, or a status flag for an interrupt-driven driver. Both kinds of report are suppressed while the link is idle and the buffer is empty.

The host side also gets one-cycle pulses when it writes into a full buffer or reads from an empty one.

Top module: `fifo_thr_dma`

## Requirements
- R1: After reset the configuration reads 0x1F00 (almost-full level 31, almost-empty level 0, both DMA enables off). The buffer is empty, and every request, flag and error pulse is low.
- R2: The configuration word has the receive-DMA enable in bit 15, the almost-full level in bits 12:8, the transmit-DMA enable in bit 7 and the almost-empty level in bits 4:0. Bits 14:13 and 6:5 read back as zero, so writing 0xFFFF reads back 0x9F9F.
- R3: Words leave in the order they entered, and the indices wrap modulo 32, so traffic longer than 32 words stays in order.
- R4: A host write while 32 words are held is discarded. `host_overrun` is high for the one cycle after that write's clock edge.
- R5: A host read of an empty buffer leaves the pointers unchanged, and `host_rdata` keeps showing the head word. `host_underrun` is high for the one cycle after that read's clock edge.
- R6: In card-to-host mode (`dir_rx`=1), when occupancy is strictly greater than the almost-full level and receive DMA is enabled, `dma_rx_req` is high. It follows the stored occupancy combinationally.
- R7: Under the R6 occupancy condition with receive DMA disabled, `stat_af` is high instead. It is a register that reflects the state captured at the same edge as the occupancy.
- R8: In host-to-card mode (`dir_rx`=0), when occupancy is strictly less than the almost-empty level and transmit DMA is enabled, `dma_tx_req` is high.
- R9: Under the R8 occupancy condition with transmit DMA disabled, `stat_ae` is high instead.
- R10: When a direction's condition does not hold, that direction's request and flag are both low.
- R11: While `xfer_active` is low and the buffer is empty, both requests and both flags are low.
- R12: A configuration write that sets a DMA enable clears the matching flag at the same clock edge.
- R13: A push and a pop in the same cycle both take effect, and occupancy is unchanged. On an empty buffer the pop is refused and the pushed word becomes the head.
- R14: Host writes are accepted only in host-to-card mode and card pushes only in card-to-host mode. A push from the other side is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1 = card-to-host, 0 = host-to-card |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 16 | Host push data |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | 16 | Head word seen by the host |
| host_overrun | output | 1 | Host wrote while full (one-cycle pulse) |
| host_underrun | output | 1 | Host read while empty (one-cycle pulse) |
| card_push | input | 1 | Card push strobe |
| card_wdata | input | 16 | Card push data |
| card_pop | input | 1 | Card pop strobe |
| card_rdata | output | 16 | Head word seen by the card |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| stat_af | output | 1 | Almost-full service flag |
| stat_ae | output | 1 | Almost-empty service flag |

## Verification
A push and a pop can land on the same clock edge. The bench provokes this with a host write paired with a card pop, both on a partly filled buffer and on an empty one. It judges the result by the heads that follow and by the almost-empty threshold.

A configuration write can also coincide with a live threshold crossing. Enabling receive DMA while the almost-full flag is set must hand the condition from the flag to the request line at one edge. The bench checks that both outputs move together.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;
  localparam int LVL_W  = 5;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic             rx_dma_en;
    logic [LVL_W-1:0] af_lvl;
    logic             tx_dma_en;
    logic [LVL_W-1:0] ae_lvl;
  } buf_cfg_t;
endpackage

// File: rtl/fifo_thr_store.sv
module fifo_thr_store #(
  parameter int WIDTH = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [AW:0]      count_q_o,
  output logic [AW:0]      count_d_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [AW:0]      count_q, count_d;
  logic             push_ok, pop_ok;

  always_comb begin
    full_o   = (count_q == FULL_CNT);
    empty_o  = (count_q == '0);
    push_ok  = push_i && !full_o;
    pop_ok   = pop_i && !empty_o;
    wr_ptr_d = wr_ptr_q + AW'(push_ok);
    rd_ptr_d = rd_ptr_q + AW'(pop_ok);
    count_d  = count_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (push_ok && (wr_ptr_q == AW'(i)))
        mem_q[i] <= push_data_i;
    end
  end

  assign head_o    = mem_q[rd_ptr_q];
  assign count_q_o = count_q;
  assign count_d_o = count_d;

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_q == FULL_CNT));

  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> ($stable(rd_ptr_q) && count_q == '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
endmodule

// File: rtl/fifo_thr_level.sv
module fifo_thr_level
  import fifo_thr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     xfer_i,
  input  logic     dir_rx_i,
  input  buf_cfg_t cfg_q_i,
  input  buf_cfg_t cfg_d_i,
  input  logic [AW:0] cnt_q_i,
  input  logic [AW:0] cnt_d_i,
  output logic     dma_rx_o,
  output logic     dma_tx_o,
  output logic     flag_af_o,
  output logic     flag_ae_o
);
  logic live_q, live_d;
  logic af_d, ae_d;

  // requests: combinational from stored occupancy and stored configuration
  always_comb begin
    live_q   = xfer_i || (cnt_q_i != '0);
    dma_rx_o = live_q && dir_rx_i && (cnt_q_i > (AW+1)'(cfg_q_i.af_lvl))
               && cfg_q_i.rx_dma_en;
    dma_tx_o = live_q && !dir_rx_i && (cnt_q_i < (AW+1)'(cfg_q_i.ae_lvl))
               && cfg_q_i.tx_dma_en;
  end

  // flags: next state from next occupancy and next configuration
  always_comb begin
    live_d = xfer_i || (cnt_d_i != '0);
    af_d   = live_d && dir_rx_i && (cnt_d_i > (AW+1)'(cfg_d_i.af_lvl))
             && !cfg_d_i.rx_dma_en;
    ae_d   = live_d && !dir_rx_i && (cnt_d_i < (AW+1)'(cfg_d_i.ae_lvl))
             && !cfg_d_i.tx_dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_af_o <= 1'b0;
      flag_ae_o <= 1'b0;
    end else begin
      flag_af_o <= af_d;
      flag_ae_o <= ae_d;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_i && cnt_q_i == '0) |-> (!dma_rx_o && !dma_tx_o));

  // R7
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_rx_o && flag_af_o));

  // R9
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_tx_o && flag_ae_o));
endmodule

// File: rtl/fifo_thr_dma.sv
module fifo_thr_dma
  import fifo_thr_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             dir_rx,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  output logic             host_overrun,
  output logic             host_underrun,
  input  logic             card_push,
  input  logic [WIDTH-1:0] card_wdata,
  input  logic             card_pop,
  output logic [WIDTH-1:0] card_rdata,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic             stat_af,
  output logic             stat_ae
);
  localparam buf_cfg_t CFG_RST = '{rx_dma_en: 1'b0, af_lvl: '1,
                                   tx_dma_en: 1'b0, ae_lvl: '0};

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  buf_cfg_t         cfg_q, cfg_d;
  logic             push, pop, host_push, host_pop;
  logic [WIDTH-1:0] push_data, head;
  logic [AW:0]      cnt_q, cnt_d;
  logic             full, empty;
  logic             ovr_d, unr_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.rx_dma_en = cfg_wdata[15];
      cfg_d.af_lvl    = cfg_wdata[12:8];
      cfg_d.tx_dma_en = cfg_wdata[7];
      cfg_d.ae_lvl    = cfg_wdata[4:0];
    end
    host_push = host_wr && !dir_rx;
    host_pop  = host_rd && dir_rx;
    push      = host_push || (card_push && dir_rx);
    pop       = host_pop || (card_pop && !dir_rx);
    push_data = dir_rx ? card_wdata : host_wdata;
    ovr_d     = host_push && full;
    unr_d     = host_pop && empty;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q         <= CFG_RST;
      host_overrun  <= 1'b0;
      host_underrun <= 1'b0;
    end else begin
      cfg_q         <= cfg_d;
      host_overrun  <= ovr_d;
      host_underrun <= unr_d;
    end
  end

  assign cfg_rdata  = {cfg_q.rx_dma_en, 2'b00, cfg_q.af_lvl,
                       cfg_q.tx_dma_en, 2'b00, cfg_q.ae_lvl};
  assign host_rdata = head;
  assign card_rdata = head;

  fifo_thr_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .count_q_o   (cnt_q),
    .count_d_o   (cnt_d),
    .full_o      (full),
    .empty_o     (empty)
  );

  fifo_thr_level #(.AW(AW)) u_level (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .xfer_i    (xfer_active),
    .dir_rx_i  (dir_rx),
    .cfg_q_i   (cfg_q),
    .cfg_d_i   (cfg_d),
    .cnt_q_i   (cnt_q),
    .cnt_d_i   (cnt_d),
    .dma_rx_o  (dma_rx_req),
    .dma_tx_o  (dma_tx_req),
    .flag_af_o (stat_af),
    .flag_ae_o (stat_ae)
  );

  // R12
  rxen_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && cfg_wdata[15]) |=> !stat_af);

  // R12
  txen_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && cfg_wdata[7]) |=> !stat_ae);

  // R2
  cfg_rb_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & 16'h9F9F)));

  // R4
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_wr && !dir_rx && full) |=> host_overrun);
endmodule

// File: tb/sim_fifo_thr_dma.sv
`timescale 1ns/1ps
module sim_fifo_thr_dma;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_active, dir_rx, cfg_we, host_wr, host_rd, card_push, card_pop;
  logic [15:0] cfg_wdata, host_wdata, card_wdata;
  logic [15:0] cfg_rdata, host_rdata, card_rdata;
  logic        host_overrun, host_underrun, dma_rx_req, dma_tx_req, stat_af, stat_ae;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fifo_thr_dma u0 (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .dir_rx(dir_rx),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_overrun(host_overrun),
    .host_underrun(host_underrun), .card_push(card_push),
    .card_wdata(card_wdata), .card_pop(card_pop), .card_rdata(card_rdata),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .stat_af(stat_af), .stat_ae(stat_ae)
  );

  // vector: dir_rx, xfer, cfg word, pushes, expected {dma_rx,dma_tx,af,ae}, tag
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h8300, 6'd4,  4'b1000, 4'd6},   // R6  4 > 3, rx DMA on
    {1'b1, 1'b1, 16'h8300, 6'd3,  4'b0000, 4'd10},  // R10 3 not > 3
    {1'b1, 1'b1, 16'h0300, 6'd4,  4'b0010, 4'd7},   // R7  flag instead of DMA
    {1'b1, 1'b1, 16'h0300, 6'd3,  4'b0000, 4'd10},  // R10
    {1'b0, 1'b1, 16'h0085, 6'd4,  4'b0100, 4'd8},   // R8  4 < 5, tx DMA on
    {1'b0, 1'b1, 16'h0085, 6'd5,  4'b0000, 4'd10},  // R10 5 not < 5
    {1'b0, 1'b1, 16'h0005, 6'd2,  4'b0001, 4'd9},   // R9  flag instead of DMA
    {1'b0, 1'b1, 16'h0005, 6'd0,  4'b0001, 4'd9},   // R9  empty but active
    {1'b0, 1'b0, 16'h0005, 6'd0,  4'b0000, 4'd11},  // R11 idle and empty
    {1'b0, 1'b0, 16'h0085, 6'd0,  4'b0000, 4'd11},  // R11 idle and empty, DMA on
    {1'b1, 1'b0, 16'h0000, 6'd1,  4'b0010, 4'd7},   // R7  idle but non-empty
    {1'b1, 1'b1, 16'h9F00, 6'd32, 4'b1000, 4'd6}    // R6  full, 32 > 31
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    xfer_active = 1'b0; dir_rx = 1'b0; cfg_we = 1'b0; host_wr = 1'b0;
    host_rd = 1'b0; card_push = 1'b0; card_pop = 1'b0;
    cfg_wdata = '0; host_wdata = '0; card_wdata = '0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic cfg_write(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
  endtask

  task automatic hwr(input logic [15:0] d);
    host_wr = 1'b1; host_wdata = d; step(); host_wr = 1'b0;
  endtask

  task automatic cpush(input logic [15:0] d);
    card_push = 1'b1; card_wdata = d; step(); card_push = 1'b0;
  endtask

  task automatic cpop();
    card_pop = 1'b1; step(); card_pop = 1'b0;
  endtask

  task automatic hrd();
    host_rd = 1'b1; step(); host_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk("R1 outputs", {10'd0, dma_rx_req, dma_tx_req, stat_af, stat_ae,
                       host_overrun, host_underrun}, 16'h0000);

    // R2 field layout and reserved bits
    cfg_write(16'hFFFF);
    chk("R2 readback", cfg_rdata, 16'h9F9F);

    // threshold table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      dir_rx      = VEC[v][31];
      xfer_active = VEC[v][30];
      cfg_write(VEC[v][29:14]);
      for (int k = 0; k < int'(VEC[v][13:8]); k++) begin
        if (dir_rx) cpush(16'(k)); else hwr(16'(k));
      end
      repeat (2) step();
      chk($sformatf("R%0d table vector %0d", VEC[v][3:0], v),
          {12'd0, dma_rx_req, dma_tx_req, stat_af, stat_ae}, {12'd0, VEC[v][7:4]});
    end

    // R3 order and wrap across 40 words
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b0;
    for (int k = 0; k < 20; k++) hwr(16'h0100 + 16'(k));
    for (int k = 0; k < 20; k++) begin
      chk("R3 order first pass", card_rdata, 16'h0100 + 16'(k));
      cpop();
    end
    for (int k = 0; k < 20; k++) hwr(16'h0200 + 16'(k));
    for (int k = 0; k < 20; k++) begin
      chk("R3 order after wrap", card_rdata, 16'h0200 + 16'(k));
      cpop();
    end

    // R4 overrun on full
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b0;
    for (int k = 0; k < 32; k++) hwr(16'h0300 + 16'(k));
    chk("R4 no pulse before", {15'd0, host_overrun}, 16'd0);
    hwr(16'hDEAD);
    chk("R4 overrun pulse", {15'd0, host_overrun}, 16'd1);
    step();
    chk("R4 pulse one cycle", {15'd0, host_overrun}, 16'd0);
    for (int k = 0; k < 32; k++) begin
      chk("R4 stored data", card_rdata, 16'h0300 + 16'(k));
      cpop();
    end
    cfg_write(16'h0081);
    chk("R4 discarded word absent", {15'd0, dma_tx_req}, 16'd1);

    // R5 underrun on empty
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b1;
    hrd();
    chk("R5 underrun pulse", {15'd0, host_underrun}, 16'd1);
    chk("R5 head unchanged", host_rdata, 16'h0000);
    step();
    chk("R5 pulse one cycle", {15'd0, host_underrun}, 16'd0);
    cpush(16'hBEEF);
    chk("R5 pointers unchanged", host_rdata, 16'hBEEF);

    // R12 enabling receive DMA moves the report from flag to request
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b1;
    cfg_write(16'h0000);
    cpush(16'h0011);
    step();
    chk("R12 flag before enable", {15'd0, stat_af}, 16'd1);
    cfg_write(16'h8000);
    chk("R12 flag cleared", {14'd0, dma_rx_req, stat_af}, 16'b10);

    // R13 push and pop together
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b0;
    cfg_write(16'h0081);
    hwr(16'h00AA);
    hwr(16'h00BB);
    host_wr = 1'b1; host_wdata = 16'h00CC; card_pop = 1'b1;
    step();
    host_wr = 1'b0; card_pop = 1'b0;
    chk("R13 head after joint op", card_rdata, 16'h00BB);
    cpop();
    chk("R13 pushed word kept", card_rdata, 16'h00CC);
    cpop();
    chk("R13 count consistent", {15'd0, dma_tx_req}, 16'd1);
    host_wr = 1'b1; host_wdata = 16'h00DD; card_pop = 1'b1;
    step();
    host_wr = 1'b0; card_pop = 1'b0;
    chk("R13 empty joint head", card_rdata, 16'h00DD);
    chk("R13 empty joint count", {15'd0, dma_tx_req}, 16'd0);

    // R14 pushes from the wrong side are ignored
    do_reset();
    xfer_active = 1'b1; dir_rx = 1'b1;
    cfg_write(16'h8000);
    hwr(16'h1234);
    step();
    chk("R14 host write ignored", {15'd0, dma_rx_req}, 16'd0);
    cpush(16'h5555);
    chk("R14 card push taken", host_rdata, 16'h5555);
    chk("R14 card push counted", {15'd0, dma_rx_req}, 16'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule